// File: doc/BRIEF.md
# Coprocessor Bus-Grant Control Registers

This block is a small register window through which a host processor supervises a secondary processor. It holds two control lines: a request for the shared bus and a hold-in-reset line for the secondary processor. The host reaches them through byte-wide reads and writes on a plain synchronous bus, with an address, a write byte, a read byte and separate read and write strobes. Byte addresses are decoded within a 16 KB window.

The reset line is asserted by writing a zero byte and released by writing any nonzero byte. The bus-request line works the other way round: it is set by a nonzero byte and cleared by a zero byte. One status byte can be read back. Its low bit is one only while the bus request and the reset line are both asserted. A write to the memory-mode slot is accepted and changes nothing. Any other read or write is flagged on a one-cycle error pulse.

Top module: `copro_ctl_regs`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it is released, `bus_req` is 0, `cop_reset` is 1, `rdata` is 0x00 and `err` is 0.
- R2: A write strobe at offset 0x100 sets `bus_req` to 1 on that clock edge if `wdata` is nonzero, and to 0 if `wdata` is zero. No other access changes `bus_req`.
- R3: A write strobe at offset 0x200 sets `cop_reset` to 1 on that clock edge if `wdata` is zero, and to 0 if `wdata` is nonzero. No other access changes `cop_reset`.
- R4: A read strobe at offset 0x100 gives `rdata` = 0x01 in the next cycle if `bus_req` and `cop_reset` were both 1 when the strobe was sampled. Otherwise it gives 0x00.
- R5: A write at offset 0x000 (memory-mode slot) is accepted. It changes neither control line and raises no `err`.
- R6: A write at any offset other than 0x000, 0x100 or 0x200 changes no state. It raises `err` for exactly the one cycle after the strobe.
- R7: A read at any offset other than 0x100 (this includes 0x000 and 0x200) returns `rdata` = 0x00 and raises `err` for the one cycle after the strobe.
- R8: In the cycle after a cycle with no read strobe, `rdata` is 0x00. In the cycle after a cycle with no unmapped access, `err` is 0.
- R9: When a read and a write at offset 0x100 are strobed in the same cycle, the status returned reflects the control lines as they were before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 14 | Byte offset within the window |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rdata | output | 8 | Registered read byte |
| err | output | 1 | One-cycle unmapped-access pulse |
| bus_req | output | 1 | Bus request to the secondary processor |
| cop_reset | output | 1 | Hold-in-reset to the secondary processor, active high |

## Verification
A wrong control-register value shows directly on `bus_req` or `cop_reset` at the edge after the write. It also shows one cycle later in the status byte, the next time the host reads offset 0x100. A decode fault is seen one cycle after the strobe, either as a missing or stray `err` pulse or as a control line that moves on the wrong offset. A stale read register shows in the cycle after an idle cycle as a nonzero `rdata`. Because every state element reaches a port within one cycle, each fault is caught on the access that exposes it.

// File: rtl/copro_pkg.sv
package copro_pkg;

   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_MODE = 2'd1,
      RG_REQ  = 2'd2,
      RG_HOLD = 2'd3
   } region_e;

endpackage

// File: rtl/copro_decode.sv
module copro_decode
   import copro_pkg::*;
#(
   parameter int ADDR_W   = 14,
   parameter int OFS_MODE = 'h000,
   parameter int OFS_REQ  = 'h100,
   parameter int OFS_HOLD = 'h200
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);

   localparam int SPAN = 1 << ADDR_W;

   if (OFS_MODE >= SPAN || OFS_REQ >= SPAN || OFS_HOLD >= SPAN) begin : g_bad_span
      $error("copro_decode: register offset outside the address window");
   end
   if (OFS_MODE == OFS_REQ || OFS_MODE == OFS_HOLD || OFS_REQ == OFS_HOLD) begin : g_bad_dup
      $error("copro_decode: register offsets must be distinct");
   end

   localparam logic [ADDR_W-1:0] A_MODE = OFS_MODE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_REQ  = OFS_REQ[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_HOLD = OFS_HOLD[ADDR_W-1:0];

   always_comb begin
      unique case (addr)
         A_MODE:  region = RG_MODE;
         A_REQ:   region = RG_REQ;
         A_HOLD:  region = RG_HOLD;
         default: region = RG_NONE;
      endcase
   end

endmodule

// File: rtl/copro_ctl_bank.sv
module copro_ctl_bank
   import copro_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  region_e           region,
   input  logic [DATA_W-1:0] wdata,
   output logic              req_q,
   output logic              hold_q
);

   logic byte_nz;
   assign byte_nz = |wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q  <= 1'b0;
         hold_q <= 1'b1;
      end else if (wr_en) begin
         if (region == RG_REQ)  req_q  <= byte_nz;
         if (region == RG_HOLD) hold_q <= ~byte_nz;
      end
   end

endmodule

// File: rtl/copro_rd_path.sv
module copro_rd_path
   import copro_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  region_e           region,
   input  logic              req_q,
   input  logic              hold_q,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   logic              status_bit;
   logic [DATA_W-1:0] status_word;
   logic              bad_rd;
   logic              bad_wr;

   assign status_bit = req_q & hold_q;

   if (DATA_W == 1) begin : g_narrow
      assign status_word = status_bit;
   end else begin : g_wide
      assign status_word = {{(DATA_W-1){1'b0}}, status_bit};
   end

   assign bad_rd = rd_en && (region != RG_REQ);
   assign bad_wr = wr_en && (region == RG_NONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         rdata <= (rd_en && region == RG_REQ) ? status_word : '0;
         err   <= bad_rd | bad_wr;
      end
   end

endmodule

// File: rtl/copro_ctl_regs.sv
module copro_ctl_regs
   import copro_pkg::*;
#(
   parameter int ADDR_W   = 14,
   parameter int DATA_W   = 8,
   parameter int OFS_MODE = 'h000,
   parameter int OFS_REQ  = 'h100,
   parameter int OFS_HOLD = 'h200
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rdata,
   output logic              err,
   output logic              bus_req,
   output logic              cop_reset
);

   if (DATA_W < 1) begin : g_bad_width
      $error("copro_ctl_regs: DATA_W must be at least 1");
   end

   region_e region;
   logic    req_q;
   logic    hold_q;

   copro_decode #(
      .ADDR_W  (ADDR_W),
      .OFS_MODE(OFS_MODE),
      .OFS_REQ (OFS_REQ),
      .OFS_HOLD(OFS_HOLD)
   ) u_decode (
      .addr  (addr),
      .region(region)
   );

   copro_ctl_bank #(.DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en),
      .region(region),
      .wdata (wdata),
      .req_q (req_q),
      .hold_q(hold_q)
   );

   copro_rd_path #(.DATA_W(DATA_W)) u_rd (
      .clk   (clk),
      .rst   (rst),
      .rd_en (rd_en),
      .wr_en (wr_en),
      .region(region),
      .req_q (req_q),
      .hold_q(hold_q),
      .rdata (rdata),
      .err   (err)
   );

   assign bus_req   = req_q;
   assign cop_reset = hold_q;

endmodule

// File: rtl/copro_ctl_chk.sv
module copro_ctl_chk #(
   parameter int ADDR_W   = 14,
   parameter int DATA_W   = 8,
   parameter int OFS_MODE = 'h000,
   parameter int OFS_REQ  = 'h100,
   parameter int OFS_HOLD = 'h200
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              rd_en,
   input logic              wr_en,
   input logic [DATA_W-1:0] rdata,
   input logic              err,
   input logic              bus_req,
   input logic              cop_reset
);

   logic at_mode, at_req, at_hold, unmapped;
   assign at_mode  = (addr == OFS_MODE[ADDR_W-1:0]);
   assign at_req   = (addr == OFS_REQ[ADDR_W-1:0]);
   assign at_hold  = (addr == OFS_HOLD[ADDR_W-1:0]);
   assign unmapped = (rd_en && !at_req) || (wr_en && !at_mode && !at_req && !at_hold);

   // R2
   p_req_write_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && at_req) |=> (bus_req == ($past(wdata) != '0)));
   p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && at_req) |=> $stable(bus_req));
   // R3
   p_rst_write_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && at_hold) |=> (cop_reset == ($past(wdata) == '0)));
   p_rst_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && at_hold) |=> $stable(cop_reset));
   // R4, R9
   p_status_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_en && at_req) |=> (rdata == DATA_W'($past(bus_req && cop_reset))));
   // R6, R7
   p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      unmapped |=> err);
   // R7
   p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !at_req) |=> (rdata == '0));
   // R8
   p_idle_rdata_r8: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> (rdata == '0));
   p_no_err_r8: assert property (@(posedge clk) disable iff (rst)
      !unmapped |=> !err);

endmodule

bind copro_ctl_regs copro_ctl_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .OFS_MODE(OFS_MODE),
   .OFS_REQ (OFS_REQ),
   .OFS_HOLD(OFS_HOLD)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .addr     (addr),
   .wdata    (wdata),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .rdata    (rdata),
   .err      (err),
   .bus_req  (bus_req),
   .cop_reset(cop_reset)
);

// File: tb/tb_copro_ctl_regs.sv
module tb_copro_ctl_regs;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [13:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  rdata;
   logic        err;
   logic        bus_req;
   logic        cop_reset;

   always #4 clk = ~clk;   // 125 MHz

   copro_ctl_regs dut (
      .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
      .rd_en(rd_en), .wr_en(wr_en), .rdata(rdata), .err(err),
      .bus_req(bus_req), .cop_reset(cop_reset)
   );

   typedef struct {
      int    stamp;
      logic [7:0] x_rdata;
      logic  x_err;
      logic  x_req;
      logic  x_rst;
      string tag;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   bit    m_req = 1'b0;
   bit    m_rst = 1'b1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   // monitor: pops items whose result cycle has arrived
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].stamp == cyc) begin
         item_t it;
         it = q.pop_front();
         chk(it.tag, "rdata",     rdata,     it.x_rdata);
         chk(it.tag, "err",       err,       it.x_err);
         chk(it.tag, "bus_req",   bus_req,   it.x_req);
         chk(it.tag, "cop_reset", cop_reset, it.x_rst);
      end
   end

   // driver: called at a negedge, pushes expectation, drives one cycle
   task automatic access(bit rd, bit wr, int a, int d, string tag);
      item_t it;
      bit    mapped_wr;
      mapped_wr  = (a == 'h000) || (a == 'h100) || (a == 'h200);
      it.stamp   = cyc + 1;
      it.x_rdata = (rd && a == 'h100) ? {7'b0, m_req & m_rst} : 8'h00;
      it.x_err   = (rd && a != 'h100) || (wr && !mapped_wr);
      if (wr && a == 'h100) m_req = (d[7:0] != 0);
      if (wr && a == 'h200) m_rst = (d[7:0] == 0);
      it.x_req   = m_req;
      it.x_rst   = m_rst;
      it.tag     = tag;
      q.push_back(it);
      rd_en = rd;
      wr_en = wr;
      addr  = a[13:0];
      wdata = d[7:0];
      @(negedge clk);
      rd_en = 1'b0;
      wr_en = 1'b0;
   endtask

   task automatic apply_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset values while reset is held
      chk("R1", "rdata",     rdata,     0);
      chk("R1", "err",       err,       0);
      chk("R1", "bus_req",   bus_req,   0);
      chk("R1", "cop_reset", cop_reset, 1);
      rst   = 1'b0;
      m_req = 1'b0;
      m_rst = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      @(negedge clk);
      apply_reset();
      access(0, 0, 'h000, 0, "R1");        // R1 first cycle after release
      access(0, 0, 'h100, 0, "R8");        // R8 idle
      access(1, 0, 'h100, 0, "R4");        // R4 status 0 after reset
      access(0, 1, 'h100, 'h5A, "R2");     // R2 set
      access(1, 0, 'h100, 0, "R4");        // R4 both asserted -> 1
      access(0, 0, 'h100, 0, "R8");        // R8 rdata back to zero
      access(0, 1, 'h200, 'h01, "R3");     // R3 release
      access(1, 0, 'h100, 0, "R4");        // R4 -> 0
      access(0, 1, 'h200, 'h00, "R3");     // R3 assert
      access(0, 1, 'h100, 'h00, "R2");     // R2 clear
      access(1, 0, 'h100, 0, "R4");
      access(0, 1, 'h100, 'h80, "R2");     // R2 high bit only counts
      access(0, 1, 'h000, 'hFF, "R5");     // R5 mode slot
      access(1, 0, 'h100, 0, "R5");        // R5 status unchanged
      access(0, 1, 'h300, 'h00, "R6");     // R6 unmapped write
      access(0, 0, 'h300, 0, "R6");        // R6 pulse lasts one cycle
      access(0, 1, 'h101, 'h00, "R6");
      access(0, 1, 'h3FFF, 'h00, "R6");
      access(0, 1, 'h201, 'h07, "R6");
      access(1, 0, 'h100, 0, "R6");        // R6 state intact
      access(1, 0, 'h000, 0, "R7");        // R7 reads of non-status slots
      access(1, 0, 'h200, 0, "R7");
      access(1, 0, 'h2A5, 0, "R7");
      access(0, 0, 'h000, 0, "R8");
      access(1, 1, 'h100, 'h00, "R9");     // R9 read sees pre-write status
      access(1, 0, 'h100, 0, "R9");
      access(0, 1, 'h100, 'h01, "R2");
      access(0, 1, 'h200, 'h00, "R3");
      @(negedge clk);
      apply_reset();                        // R1 mid-run reset
      access(1, 0, 'h100, 0, "R1");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule